// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block moves data between two memory regions, one transfer unit per step, over a simple single-cycle memory bus. Each unit is a read at the current source address followed by a write of the same data at the current destination address. The unit can be 1, 2, 4 or 8 bytes wide. After each unit the remaining count drops by one. Each address then stays fixed, steps up or steps down by the unit size.

Transfers are paced in one of two ways. Auto-request runs with no outside trigger. External request uses a request pin, detected either by level or by a rising edge. In burst mode the units run back to back. In cycle-steal mode the bus is released after every unit and the channel waits for the next request. Starting is gated by a channel enable, a master enable and three flags: NMI, address error and transfer end. Before any unit is moved, both addresses are checked for alignment against the unit size. The channel stops normally when the count is used up. It is suspended between units when a flag blocks it or an enable is withdrawn.

The controller is a five-state machine:

- IDLE: no transfer. Leaves for CHECK when the start gate opens.
- CHECK: tests alignment. Goes to IDLE with the address-error flag set, or to WAIT.
- WAIT: idle bus. Goes to IDLE on suspension, or to READ when a request is present.
- READ: drives the source address and captures the data.
- WRITE: drives the destination address and updates the count and addresses. It then goes to IDLE after the last unit, straight to READ to continue a burst, or to WAIT otherwise.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: The channel leaves IDLE only while chan_en and master_en are 1 and the NMI, address-error and transfer-end flags are all 0. No bus cycle occurs otherwise.
- R2: The unit size is encoded as cfg_size 00=1 byte, 01=2, 10=4, 11=8 bytes. If cfg_size is non-zero and either address has a non-zero bit among its low cfg_size bits, flag_ae is set and no bus cycle occurs.
- R3: Each unit is one read cycle at the source (bus_we=0) followed in the next cycle by one write cycle at the destination (bus_we=1). The write carries the read data. After the write, cur_cnt decreases by 1 and each address moves by its mode: 00 fixed, 01 up by the unit size, 10 down by the unit size, 11 fixed.
- R4: When the count reaches zero, flag_te is set and the bus goes quiet. irq equals flag_te while cfg_irq_en is 1 and stays 0 while cfg_irq_en is 0.
- R5: Withdrawing chan_en or raising nmi_in suspends the channel before its next unit, with the count and addresses kept. Re-enabling it, or clearing the flags, resumes the transfer from where it stopped.
- R6: A loaded count of 0 transfers 2^CW units.
- R7: In burst mode with auto-request, N units occupy exactly 2N consecutive bus cycles.
- R8: In cycle-steal mode (cfg_burst=0) the bus is idle for at least one cycle after every write. With auto-request, N units span 3N-1 cycles.
- R9: With external level request (cfg_ext_req=1, cfg_edge=0), a unit starts only while dreq is 1.
- R10: With external edge request (cfg_edge=1), only a low-to-high change of dreq after load counts as a request. In burst mode one edge runs the whole transfer. In cycle-steal mode each edge grants one unit.
- R11: A flag_clr pulse clears flag_te, flag_ae and flag_nmi. While flag_te is 1 no new transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Number of units (0 means 2^CW) |
| cfg_size | input | 2 | Unit size code |
| cfg_src_mode | input | 2 | Source address mode |
| cfg_dst_mode | input | 2 | Destination address mode |
| cfg_burst | input | 1 | 1 = burst, 0 = cycle steal |
| cfg_ext_req | input | 1 | 1 = external request, 0 = auto-request |
| cfg_edge | input | 1 | 1 = edge detection, 0 = level detection |
| cfg_irq_en | input | 1 | Transfer-end interrupt enable |
| load | input | 1 | Latch configuration in IDLE |
| chan_en | input | 1 | Channel enable |
| master_en | input | 1 | Master enable |
| nmi_in | input | 1 | Sets the NMI flag |
| flag_clr | input | 1 | Clears all flags |
| dreq | input | 1 | External request line |
| bus_valid | output | 1 | Bus cycle active |
| bus_we | output | 1 | 1 = write cycle |
| bus_addr | output | AW | Bus address |
| bus_size | output | 2 | Unit size of the cycle |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid in the read cycle |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |
| cur_cnt | output | CW | Remaining count |
| flag_te | output | 1 | Transfer-end flag |
| flag_ae | output | 1 | Address-error flag |
| flag_nmi | output | 1 | NMI flag |
| irq | output | 1 | Transfer-end interrupt request |

## Verification
A corrupted state register shows at the bus within one or two cycles. The symptoms are a write with no preceding read, an address that jumps off its expected sequence, or a burst whose span is not twice its unit count. A wrong count or address register shows at the next bus cycle as a mismatched address, and at the end as a wrong number of units or a wrong final address. A flag that is stuck or lost shows within a few cycles, as bus activity that should be blocked or as a channel that never starts.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_WAIT,
        S_READ,
        S_WRITE
    } dmac_state_t;

    localparam logic [1:0] AM_FIXED = 2'b00;
    localparam logic [1:0] AM_INC   = 2'b01;
    localparam logic [1:0] AM_DEC   = 2'b10;
endpackage

// File: rtl/dmac_addr_unit.sv
module dmac_addr_unit #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    mode,
    input  logic [1:0]    size,
    output logic [AW-1:0] addr_next,
    output logic          misaligned
);
    import dmac_pkg::*;

    logic [AW-1:0] step;

    always_comb begin
        step = AW'(1) << size;
        unique case (mode)
            AM_INC:  addr_next = addr + step;
            AM_DEC:  addr_next = addr - step;
            default: addr_next = addr;
        endcase
        unique case (size)
            2'd0:    misaligned = 1'b0;
            2'd1:    misaligned = addr[0];
            2'd2:    misaligned = |addr[1:0];
            default: misaligned = |addr[2:0];
        endcase
    end
endmodule

// File: rtl/dmac_req_detect.sv
module dmac_req_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq,
    input  logic clr,
    input  logic consume,
    output logic edge_hit
);
    logic dreq_q;
    logic pend;
    logic rise;

    assign rise     = dreq & ~dreq_q;
    assign edge_hit = pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dreq_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            dreq_q <= dreq;
            if (clr)          pend <= 1'b0;
            else if (rise)    pend <= 1'b1;
            else if (consume) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl #(
    parameter int AW = 32,
    parameter int DW = 64,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    cfg_size,
    input  logic [1:0]    cfg_src_mode,
    input  logic [1:0]    cfg_dst_mode,
    input  logic          cfg_burst,
    input  logic          cfg_ext_req,
    input  logic          cfg_edge,
    input  logic          cfg_irq_en,
    input  logic          load,
    input  logic          chan_en,
    input  logic          master_en,
    input  logic          nmi_in,
    input  logic          flag_clr,
    input  logic          dreq,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] cur_cnt,
    output logic          flag_te,
    output logic          flag_ae,
    output logic          flag_nmi,
    output logic          irq
);
    import dmac_pkg::*;

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    dmac_state_t   state, state_nx;
    logic [DW-1:0] data_q;
    logic [AW-1:0] src_nx, dst_nx;
    logic          src_mis, dst_mis;
    logic          edge_hit, consume, load_ok;
    logic          suspend, start_ok, req_hit, keep_going, last_unit;

    dmac_addr_unit #(.AW(AW)) u_src (
        .addr(cur_src), .mode(cfg_src_mode), .size(cfg_size),
        .addr_next(src_nx), .misaligned(src_mis)
    );

    dmac_addr_unit #(.AW(AW)) u_dst (
        .addr(cur_dst), .mode(cfg_dst_mode), .size(cfg_size),
        .addr_next(dst_nx), .misaligned(dst_mis)
    );

    dmac_req_detect u_req (
        .clk(clk), .rst_n(rst_n), .dreq(dreq),
        .clr(load_ok), .consume(consume), .edge_hit(edge_hit)
    );

    assign load_ok    = load && (state == S_IDLE);
    assign suspend    = flag_nmi | flag_ae | ~chan_en | ~master_en;
    assign start_ok   = ~suspend & ~flag_te;
    assign req_hit    = ~cfg_ext_req | (cfg_edge ? edge_hit : dreq);
    assign keep_going = ~suspend & cfg_burst & (~cfg_ext_req | cfg_edge | dreq);
    assign last_unit  = (cur_cnt == CNT_ONE);
    assign consume    = (state == S_WAIT) && !suspend && req_hit && cfg_ext_req && cfg_edge;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start_ok) state_nx = S_CHECK;
            S_CHECK: state_nx = (src_mis | dst_mis) ? S_IDLE : S_WAIT;
            S_WAIT: begin
                if (suspend)      state_nx = S_IDLE;
                else if (req_hit) state_nx = S_READ;
            end
            S_READ:  state_nx = S_WRITE;
            S_WRITE: begin
                if (last_unit)       state_nx = S_IDLE;
                else if (keep_going) state_nx = S_READ;
                else                 state_nx = S_WAIT;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // channel registers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_src  <= '0;
            cur_dst  <= '0;
            cur_cnt  <= '0;
            data_q   <= '0;
            flag_te  <= 1'b0;
            flag_ae  <= 1'b0;
            flag_nmi <= 1'b0;
        end else begin
            if (load_ok) begin
                cur_src <= cfg_src;
                cur_dst <= cfg_dst;
                cur_cnt <= cfg_count;
            end
            if (state == S_READ) data_q <= bus_rdata;
            if (state == S_WRITE) begin
                cur_src <= src_nx;
                cur_dst <= dst_nx;
                cur_cnt <= cur_cnt - CNT_ONE;
            end
            if (state == S_WRITE && last_unit) flag_te <= 1'b1;
            else if (flag_clr)                 flag_te <= 1'b0;
            if (state == S_CHECK && (src_mis | dst_mis)) flag_ae <= 1'b1;
            else if (flag_clr)                           flag_ae <= 1'b0;
            if (nmi_in)        flag_nmi <= 1'b1;
            else if (flag_clr) flag_nmi <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        bus_valid = (state == S_READ) || (state == S_WRITE);
        bus_we    = (state == S_WRITE);
        bus_addr  = (state == S_WRITE) ? cur_dst : cur_src;
        bus_size  = cfg_size;
        bus_wdata = data_q;
        irq       = flag_te & cfg_irq_en;
    end

    p_start_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we) |-> ($past(chan_en) && $past(master_en)
                                    && !$past(flag_nmi) && !$past(flag_te)));

    p_ae_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ae |-> !bus_valid);

    p_rw_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we) |=> (bus_valid && bus_we));

    p_count_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we) |=> (cur_cnt == CW'($past(cur_cnt) - CNT_ONE)));

    p_te_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_te |-> !bus_valid);

    p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && !cfg_burst) |=> !bus_valid);
endmodule

// File: tb/sim_dma_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_dma_xfer_ctrl;
    localparam int AW = 16;
    localparam int DW = 64;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0]    cfg_size = '0, cfg_src_mode = '0, cfg_dst_mode = '0;
    logic          cfg_burst = 1'b1, cfg_ext_req = 1'b0, cfg_edge = 1'b0, cfg_irq_en = 1'b0;
    logic          load = 1'b0, chan_en = 1'b0, master_en = 1'b1, nmi_in = 1'b0;
    logic          flag_clr = 1'b0, dreq = 1'b0;
    logic          bus_valid, bus_we;
    logic [AW-1:0] bus_addr, cur_src, cur_dst;
    logic [1:0]    bus_size;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic [CW-1:0] cur_cnt;
    logic          flag_te, flag_ae, flag_nmi, irq;

    int n_checks = 0, n_fail = 0, cyc = 0;
    int first_cyc, last_cyc, n_rd, n_wr, sstep, dstep;
    bit seen, prev_wr, cs_chk;
    logic [AW-1:0] exp_src, exp_dst, last_rd;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] fdata(logic [AW-1:0] a);
        return {16'hA5C3, a, ~a, a ^ 16'h0F0F};
    endfunction
    assign bus_rdata = fdata(bus_addr);

    dma_xfer_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_count(cfg_count), .cfg_size(cfg_size), .cfg_src_mode(cfg_src_mode),
        .cfg_dst_mode(cfg_dst_mode), .cfg_burst(cfg_burst), .cfg_ext_req(cfg_ext_req),
        .cfg_edge(cfg_edge), .cfg_irq_en(cfg_irq_en), .load(load), .chan_en(chan_en),
        .master_en(master_en), .nmi_in(nmi_in), .flag_clr(flag_clr), .dreq(dreq),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cur_src(cur_src), .cur_dst(cur_dst),
        .cur_cnt(cur_cnt), .flag_te(flag_te), .flag_ae(flag_ae), .flag_nmi(flag_nmi), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int step_of(logic [1:0] mode, logic [1:0] size);
        if (mode == 2'b01) return (1 << size);
        if (mode == 2'b10) return -(1 << size);
        return 0;
    endfunction

    // bus monitor: address sequence, data path, cycle-steal gaps
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_valid) begin
                if (!seen) first_cyc = cyc;
                seen = 1'b1;
                last_cyc = cyc;
            end
            if (cs_chk && prev_wr)
                chk(!bus_valid, "R8 gap after write", 64'(bus_valid), 64'd0);
            if (bus_valid && !bus_we) begin
                chk(bus_addr == exp_src, "R3 read address", 64'(bus_addr), 64'(exp_src));
                last_rd = bus_addr;
                n_rd++;
            end
            if (bus_valid && bus_we) begin
                chk(bus_addr == exp_dst, "R3 write address", 64'(bus_addr), 64'(exp_dst));
                chk(bus_wdata == fdata(last_rd), "R3 write data", bus_wdata, fdata(last_rd));
                exp_src = exp_src + AW'(sstep);
                exp_dst = exp_dst + AW'(dstep);
                n_wr++;
            end
            prev_wr = bus_valid && bus_we;
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'd150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [CW-1:0] c,
                         input logic [1:0] sz, input logic [1:0] sm, input logic [1:0] dm,
                         input bit burst, input bit ext, input bit edg, input bit ie);
        cfg_src = s; cfg_dst = d; cfg_count = c; cfg_size = sz;
        cfg_src_mode = sm; cfg_dst_mode = dm; cfg_burst = burst;
        cfg_ext_req = ext; cfg_edge = edg; cfg_irq_en = ie;
        load = 1'b1;
        tick();
        load = 1'b0;
        exp_src = s; exp_dst = d;
        sstep = step_of(sm, sz); dstep = step_of(dm, sz);
        seen = 1'b0; n_rd = 0; n_wr = 0; prev_wr = 1'b0;
        cs_chk = !burst;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 300; i++) begin
            if (flag_te || flag_ae) break;
            tick();
        end
    endtask

    task automatic stop_clear();
        chan_en = 1'b0;
        tick();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        tick();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // reset state
        chk(!bus_valid, "R1 reset bus idle", 64'(bus_valid), 64'd0);
        chk(!flag_te && !flag_ae && !flag_nmi, "R11 reset flags", {flag_te, flag_ae, flag_nmi}, 64'd0);
        chk(!irq, "R4 reset irq", 64'(irq), 64'd0);

        // R1: start gating by master enable and NMI flag
        setup(16'h0200, 16'h0800, 4'd3, 2'd2, 2'b01, 2'b01, 1, 0, 0, 1);
        master_en = 1'b0; chan_en = 1'b1;
        tick(10);
        chk(n_rd == 0, "R1 master_en=0 blocks", 64'(n_rd), 64'd0);
        nmi_in = 1'b1; tick(); nmi_in = 1'b0;
        master_en = 1'b1;
        tick(10);
        chk(n_rd == 0, "R1 NMI flag blocks", 64'(n_rd), 64'd0);
        chk(flag_nmi, "R11 NMI flag set", 64'(flag_nmi), 64'd1);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        wait_end();
        chk(flag_te && n_wr == 3, "R4 end after gate opens", 64'(n_wr), 64'd3);
        chk(irq, "R4 irq with enable", 64'(irq), 64'd1);
        tick(10);
        chk(n_rd == 3, "R11 TE blocks restart", 64'(n_rd), 64'd3);
        stop_clear();
        chk(!flag_te && !flag_nmi, "R11 flag_clr clears", {flag_te, flag_nmi}, 64'd0);

        // R3/R4/R7: sweep size x source mode x destination mode, burst auto
        for (int sz = 0; sz < 4; sz++) begin
            for (int sm = 0; sm < 3; sm++) begin
                for (int dm = 0; dm < 3; dm++) begin
                    bit ie;
                    ie = ((sz + sm + dm) % 2) == 1;
                    setup(16'h0200, 16'h0800, 4'd3, 2'(sz), 2'(sm), 2'(dm), 1, 0, 0, ie);
                    chan_en = 1'b1;
                    wait_end();
                    chk(flag_te, "R4 transfer end flag", 64'(flag_te), 64'd1);
                    chk(irq == ie, "R4 irq follows enable", 64'(irq), 64'(ie));
                    chk(cur_cnt == 0, "R3 count zero", 64'(cur_cnt), 64'd0);
                    chk(cur_src == exp_src && cur_dst == exp_dst, "R3 final addresses",
                        {cur_src, cur_dst}, {exp_src, exp_dst});
                    chk(n_rd == 3, "R3 unit count", 64'(n_rd), 64'd3);
                    chk(last_cyc - first_cyc + 1 == 6, "R7 burst span", 64'(last_cyc - first_cyc + 1), 64'd6);
                    stop_clear();
                end
            end
        end

        // R2: misalignment sweep on source and destination
        for (int sz = 1; sz < 4; sz++) begin
            for (int off = 1; off < (1 << sz); off++) begin
                for (int side = 0; side < 2; side++) begin
                    setup(side == 0 ? 16'h0200 + 16'(off) : 16'h0200,
                          side == 1 ? 16'h0800 + 16'(off) : 16'h0800,
                          4'd2, 2'(sz), 2'b01, 2'b01, 1, 0, 0, 0);
                    chan_en = 1'b1;
                    wait_end();
                    tick(3);
                    chk(flag_ae && !flag_te, "R2 misaligned sets AE", {flag_ae, flag_te}, 64'd2);
                    chk(n_rd == 0 && !seen, "R2 no bus access", 64'(n_rd), 64'd0);
                    stop_clear();
                    chk(!flag_ae, "R11 AE cleared", 64'(flag_ae), 64'd0);
                end
            end
        end

        // R5: suspension by chan_en, burst external level
        dreq = 1'b1;
        setup(16'h0100, 16'h0400, 4'd8, 2'd2, 2'b01, 2'b10, 1, 1, 0, 0);
        chan_en = 1'b1;
        while (n_wr < 3) tick();
        chan_en = 1'b0;
        tick(8);
        begin
            int n0;
            n0 = n_wr;
            tick(8);
            chk(n_wr == n0 && n0 < 8, "R5 suspended by chan_en", 64'(n_wr), 64'(n0));
            chk(cur_cnt == CW'(8 - n0), "R5 count kept", 64'(cur_cnt), 64'(8 - n0));
        end
        chan_en = 1'b1;
        wait_end();
        chk(flag_te && n_wr == 8, "R5 resume completes", 64'(n_wr), 64'd8);
        stop_clear();

        // R5: suspension by NMI
        setup(16'h0100, 16'h0400, 4'd8, 2'd1, 2'b01, 2'b01, 1, 1, 0, 0);
        chan_en = 1'b1;
        while (n_wr < 2) tick();
        nmi_in = 1'b1; tick(); nmi_in = 1'b0;
        tick(6);
        begin
            int n0;
            n0 = n_wr;
            tick(8);
            chk(n_wr == n0 && flag_nmi, "R5 suspended by NMI", 64'(n_wr), 64'(n0));
        end
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        wait_end();
        chk(flag_te && n_wr == 8, "R5 resume after NMI clear", 64'(n_wr), 64'd8);
        stop_clear();
        dreq = 1'b0;

        // R8: cycle steal, auto-request
        setup(16'h0300, 16'h0900, 4'd4, 2'd0, 2'b01, 2'b01, 0, 0, 0, 0);
        chan_en = 1'b1;
        wait_end();
        chk(n_wr == 4, "R8 units", 64'(n_wr), 64'd4);
        chk(last_cyc - first_cyc + 1 == 11, "R8 cycle-steal span", 64'(last_cyc - first_cyc + 1), 64'd11);
        stop_clear();

        // R9: cycle steal, external level
        setup(16'h0300, 16'h0900, 4'd3, 2'd3, 2'b01, 2'b00, 0, 1, 0, 0);
        chan_en = 1'b1;
        tick(10);
        chk(n_rd == 0, "R9 no unit while dreq low", 64'(n_rd), 64'd0);
        dreq = 1'b1;
        wait_end();
        chk(flag_te && n_wr == 3, "R9 units with dreq high", 64'(n_wr), 64'd3);
        stop_clear();

        // R10: burst, edge detection; dreq already high at load
        setup(16'h0500, 16'h0A00, 4'd5, 2'd2, 2'b10, 2'b01, 1, 1, 1, 0);
        chan_en = 1'b1;
        tick(10);
        chk(n_rd == 0, "R10 high level without edge ignored", 64'(n_rd), 64'd0);
        dreq = 1'b0; tick(); dreq = 1'b1; tick(); dreq = 1'b0;
        wait_end();
        chk(flag_te && n_wr == 5, "R10 one edge runs burst", 64'(n_wr), 64'd5);
        chk(last_cyc - first_cyc + 1 == 10, "R10 burst span", 64'(last_cyc - first_cyc + 1), 64'd10);
        stop_clear();

        // R10: cycle steal, one unit per edge
        setup(16'h0500, 16'h0A00, 4'd5, 2'd1, 2'b01, 2'b01, 0, 1, 1, 0);
        chan_en = 1'b1;
        for (int k = 0; k < 2; k++) begin
            dreq = 1'b1; tick(); dreq = 1'b0; tick(6);
        end
        tick(6);
        chk(n_wr == 2 && !flag_te, "R10 two edges give two units", 64'(n_wr), 64'd2);
        stop_clear();

        // R6: count 0 means 2^CW units
        setup(16'h0040, 16'h0C00, 4'd0, 2'd0, 2'b01, 2'b01, 1, 0, 0, 0);
        chan_en = 1'b1;
        wait_end();
        chk(flag_te && n_wr == (1 << CW), "R6 zero count is maximum", 64'(n_wr), 64'(1 << CW));
        chk(cur_src == 16'h0040 + 16'(1 << CW), "R6 final source", 64'(cur_src), 64'(16'h0040 + (1 << CW)));
        stop_clear();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule